// File: doc/BRIEF.md
# Row-Buffered DRAM Bank Controller

This block fronts a single behavioural DRAM bank kept in registers. Each request address is split into a row part and a column part. A row must be opened before its columns can be used. Opening a row copies the whole row into a row buffer and clears the array copy, because the read is destructive. Column reads and writes are then served from the buffer for as long as the row stays open, which is page-mode operation. Before another row is opened, the buffer is written back into its array row.

Requests arrive on a valid/ready handshake that carries an address, a write flag, write data and a burst count. A read returns one or more words on a registered response port. A refresh timer raises a refresh request at a fixed interval. While that request is pending, the controller stops taking requests, closes any open row and then refreshes the next row in round-robin order.

The controller is a single state machine with six states:
- S_IDLE: waits for a request or for a refresh.
- S_CLOSE: counts the write-back latency.
- S_OPEN: counts the row-open latency.
- S_COL: serves one column word per cycle.
- S_REF_RD: destructively reads the refresh row.
- S_REF_WB: restores the refresh row.

The transitions are:
- S_IDLE goes to S_CLOSE when a refresh is pending and a row is open.
- S_IDLE goes to S_REF_RD when a refresh is pending and no row is open.
- S_IDLE goes to S_COL on an accepted request that hits the open row.
- S_IDLE goes to S_CLOSE on an accepted request to another row while a row is open.
- S_IDLE goes to S_OPEN on an accepted request while no row is open.
- S_CLOSE goes to S_OPEN, or to S_REF_RD when it was entered for a refresh, once its count ends.
- S_OPEN goes to S_COL once its count ends.
- S_COL goes to S_IDLE after a write or after the last word of a read.
- S_REF_RD goes to S_REF_WB, and S_REF_WB goes back to S_IDLE.

Top module: `dram_bank_ctrl`

## Requirements
- R1: The request address holds the row in its upper ROW_W bits and the column in its lower COL_W bits.
- R2: After reset every array word reads as zero. A write stores exactly one word, at the addressed column of the addressed row, and a later read of that location returns the word.
- R3: A request to the row that is already open is served with no row access. The first read word appears with rsp_valid high on the second rising edge after the accepting edge.
- R4: A request while no row is open waits OPEN_CYC extra cycles, so the first read word appears OPEN_CYC+2 edges after acceptance.
- R5: A request to a different row while a row is open waits CLOSE_CYC+OPEN_CYC extra cycles. The closed row is written back, so its data survives.
- R6: A read returns req_blen+1 words on consecutive cycles, with rsp_last high only on the final word. req_blen is ignored for writes.
- R7: A read burst that passes the last column continues at column 0 of the same row.
- R8: A refresh request is raised every REF_PERIOD cycles, and rows that are never accessed keep their data across any number of refreshes.
- R9: With no row open, a refresh holds req_ready low for 3 cycles. With a row open, it holds req_ready low for 3+CLOSE_CYC cycles and leaves the row closed.
- R10: req_ready is high only when the controller is idle with no refresh pending, and it drops in the cycle after a request is accepted.
- R11: During and right after reset, req_ready is high and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_addr | input | ROW_W+COL_W | Request address, row above column |
| req_we | input | 1 | 1 = write one word, 0 = read burst |
| req_wdata | input | DATA_W | Write word |
| req_blen | input | BL_W | Read burst length minus one |
| rsp_valid | output | 1 | Read word present |
| rsp_data | output | DATA_W | Read word |
| rsp_last | output | 1 | Final word of the burst |

## Verification
A table of writes and reads moves between two rows and an untouched row. Its measured first-word latencies separate a row hit, an access with no row open, and a row change that must close a row first. Bursts that start in mid-row and run past the last column show whether the column order wraps. Rereading a row after another row was opened shows whether the write-back happened. Refresh is then observed from idle, with a row open and after many periods. The length of each busy window and the spacing between windows show whether the row was closed, and a later read shows whether the refreshed data was kept.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_CLOSE  = 3'd1,
        S_OPEN   = 3'd2,
        S_COL    = 3'd3,
        S_REF_RD = 3'd4,
        S_REF_WB = 3'd5
    } dbc_state_e;
endpackage

// File: rtl/dbc_array.sv
// Behavioural cell array: a row read is destructive (the row is cleared),
// a row write restores a full row.
module dbc_array #(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  rd_en,
    input  logic [ROW_W-1:0]                      rd_row,
    output logic [(1<<COL_W)*DATA_W-1:0]          rd_line,
    input  logic                                  wr_en,
    input  logic [ROW_W-1:0]                      wr_row,
    input  logic [(1<<COL_W)*DATA_W-1:0]          wr_line
);
    localparam int ROW_N  = 1 << ROW_W;
    localparam int LINE_W = (1 << COL_W) * DATA_W;

    logic [LINE_W-1:0] cells [ROW_N];

    assign rd_line = cells[rd_row];

    for (genvar r = 0; r < ROW_N; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cells[r] <= '0;
            end else if (wr_en && wr_row == ROW_W'(r)) begin
                cells[r] <= wr_line;
            end else if (rd_en && rd_row == ROW_W'(r)) begin
                cells[r] <= '0;
            end
        end
    end
endmodule

// File: rtl/dbc_refresh_timer.sv
// Raises a refresh request every PERIOD cycles and tracks the next row.
module dbc_refresh_timer #(
    parameter int PERIOD = 512,
    parameter int ROW_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             pend,
    output logic [ROW_W-1:0] row
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CNT_W-1:0] tick;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick <= '0;
            pend <= 1'b0;
            row  <= '0;
        end else begin
            if (ack) begin
                pend <= 1'b0;
                row  <= row + ROW_W'(1);
            end
            if (tick == CNT_W'(PERIOD - 1)) begin
                tick <= '0;
                pend <= 1'b1;
            end else begin
                tick <= tick + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/dram_bank_ctrl.sv
module dram_bank_ctrl
    import dbc_pkg::*;
#(
    parameter int ROW_W      = 3,
    parameter int COL_W      = 2,
    parameter int DATA_W     = 8,
    parameter int BL_W       = 2,
    parameter int OPEN_CYC   = 2,
    parameter int CLOSE_CYC  = 2,
    parameter int REF_PERIOD = 512
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic                   req_we,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [BL_W-1:0]        req_blen,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_data,
    output logic                   rsp_last
);
    localparam int COL_N  = 1 << COL_W;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int LINE_W = COL_N * DATA_W;
    localparam int MAXC   = (OPEN_CYC > CLOSE_CYC) ? OPEN_CYC : CLOSE_CYC;
    localparam int CW     = $clog2(MAXC + 1);

    dbc_state_e state, state_nx;
    logic [CW-1:0] wait_cnt;

    logic                           row_open;
    logic [ROW_W-1:0]               open_row;
    logic [COL_N-1:0][DATA_W-1:0]   line_buf;
    logic [ROW_W-1:0]               cur_row;
    logic [COL_W-1:0]               cur_col;
    logic                           cur_we;
    logic [DATA_W-1:0]              cur_wdata;
    logic [BL_W-1:0]                left;
    logic                           goal_ref;

    logic                           ref_pend;
    logic                           ref_ack;
    logic [ROW_W-1:0]               ref_row;

    logic                           arr_rd_en;
    logic [ROW_W-1:0]               arr_rd_row;
    logic [LINE_W-1:0]              arr_rd_line;
    logic                           arr_wr_en;
    logic [ROW_W-1:0]               arr_wr_row;

    logic [ROW_W-1:0]               req_row;
    logic [COL_W-1:0]               req_col;
    logic                           accept;
    logic                           close_done;
    logic                           open_done;

    assign req_row    = req_addr[ADDR_W-1:COL_W];
    assign req_col    = req_addr[COL_W-1:0];
    assign req_ready  = (state == S_IDLE) && !ref_pend;
    assign accept     = req_ready && req_valid;
    assign close_done = (state == S_CLOSE) && (wait_cnt == '0);
    assign open_done  = (state == S_OPEN) && (wait_cnt == '0);
    assign ref_ack    = (state == S_REF_WB);

    // Array control: destructive read on open or refresh, restore on close
    // or refresh write-back.
    assign arr_rd_en  = open_done || (state == S_REF_RD);
    assign arr_rd_row = (state == S_REF_RD) ? ref_row : cur_row;
    assign arr_wr_en  = close_done || (state == S_REF_WB);
    assign arr_wr_row = (state == S_REF_WB) ? ref_row : open_row;

    dbc_array #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (arr_rd_en),
        .rd_row  (arr_rd_row),
        .rd_line (arr_rd_line),
        .wr_en   (arr_wr_en),
        .wr_row  (arr_wr_row),
        .wr_line (line_buf)
    );

    dbc_refresh_timer #(
        .PERIOD (REF_PERIOD),
        .ROW_W  (ROW_W)
    ) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .ack   (ref_ack),
        .pend  (ref_pend),
        .row   (ref_row)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (ref_pend) begin
                    state_nx = row_open ? S_CLOSE : S_REF_RD;
                end else if (req_valid) begin
                    if (row_open && req_row == open_row) begin
                        state_nx = S_COL;
                    end else if (row_open) begin
                        state_nx = S_CLOSE;
                    end else begin
                        state_nx = S_OPEN;
                    end
                end
            end
            S_CLOSE: begin
                if (wait_cnt == '0) begin
                    state_nx = goal_ref ? S_REF_RD : S_OPEN;
                end
            end
            S_OPEN: begin
                if (wait_cnt == '0) begin
                    state_nx = S_COL;
                end
            end
            S_COL: begin
                if (cur_we || left == '0) begin
                    state_nx = S_IDLE;
                end
            end
            S_REF_RD: state_nx = S_REF_WB;
            S_REF_WB: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // State register with latency counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            wait_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state) begin
                unique case (state_nx)
                    S_CLOSE: wait_cnt <= CW'(CLOSE_CYC - 1);
                    S_OPEN:  wait_cnt <= CW'(OPEN_CYC - 1);
                    default: wait_cnt <= '0;
                endcase
            end else if (wait_cnt != '0) begin
                wait_cnt <= wait_cnt - CW'(1);
            end
        end
    end

    // Request capture, row buffer and open-row tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open  <= 1'b0;
            open_row  <= '0;
            line_buf  <= '0;
            cur_row   <= '0;
            cur_col   <= '0;
            cur_we    <= 1'b0;
            cur_wdata <= '0;
            left      <= '0;
            goal_ref  <= 1'b0;
        end else begin
            if (accept) begin
                cur_row   <= req_row;
                cur_col   <= req_col;
                cur_we    <= req_we;
                cur_wdata <= req_wdata;
                left      <= req_we ? '0 : req_blen;
                goal_ref  <= 1'b0;
            end
            if (state == S_IDLE && ref_pend) begin
                goal_ref <= 1'b1;
            end
            if (close_done) begin
                row_open <= 1'b0;
            end
            if (open_done) begin
                line_buf <= arr_rd_line;
                row_open <= 1'b1;
                open_row <= cur_row;
            end
            if (state == S_REF_RD) begin
                line_buf <= arr_rd_line;
            end
            if (state == S_COL) begin
                if (cur_we) begin
                    line_buf[cur_col] <= cur_wdata;
                end else begin
                    cur_col <= cur_col + COL_W'(1);
                    left    <= left - BL_W'(1);
                end
            end
        end
    end

    // Registered response outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_last  <= 1'b0;
        end else begin
            rsp_valid <= (state == S_COL) && !cur_we;
            rsp_data  <= line_buf[cur_col];
            rsp_last  <= (state == S_COL) && !cur_we && (left == '0);
        end
    end
endmodule

// File: rtl/dbc_checker.sv
module dbc_checker
    import dbc_pkg::*;
#(
    parameter int ROW_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_last,
    input dbc_state_e       state,
    input logic             row_open,
    input logic             ref_pend,
    input logic             ref_ack,
    input logic [ROW_W-1:0] ref_row
);
    // R10: acceptance takes the controller out of idle
    a_r10_accept_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R6: the last marker only accompanies a word
    a_r6_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> rsp_valid);

    // R6: no word leaves in the cycle after idle
    a_r6_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |=> !rsp_valid);

    // R5: a row is only opened once the previous one was written back
    a_r5_open_after_close: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OPEN) |-> !row_open);

    // R9: refresh never runs over an open row
    a_r9_refresh_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REF_RD) |-> !row_open);

    // R8: completion only answers a pending refresh
    a_r8_ack_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> ref_pend);

    // R8: rows are refreshed in round-robin order
    a_r8_round_robin: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |=> ref_row == ROW_W'($past(ref_row) + 1'b1));
endmodule

bind dram_bank_ctrl dbc_checker #(.ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_last  (rsp_last),
    .state     (state),
    .row_open  (row_open),
    .ref_pend  (ref_pend),
    .ref_ack   (ref_ack),
    .ref_row   (ref_row)
);

// File: tb/sim_dram_bank_ctrl.sv
module sim_dram_bank_ctrl;
    localparam int ROW_W   = 3;
    localparam int COL_W   = 2;
    localparam int DATA_W  = 8;
    localparam int BL_W    = 2;
    localparam int OPEN_C  = 2;
    localparam int CLOSE_C = 3;
    localparam int REF_P   = 256;
    localparam int ADDR_W  = ROW_W + COL_W;

    // Vector: [51] we, [50:46] addr, [45:38] wdata, [37:36] blen,
    //         [35:32] expected first-word edge count, [31:0] expected words
    localparam logic [51:0] TBL [0:11] = '{
        {1'b1, 5'h09, 8'h11, 2'd0, 4'd0, 32'h0},
        {1'b1, 5'h0A, 8'h22, 2'd0, 4'd0, 32'h0},
        {1'b0, 5'h09, 8'h00, 2'd1, 4'd2, 32'h0000_2211},
        {1'b1, 5'h17, 8'h53, 2'd0, 4'd0, 32'h0},
        {1'b1, 5'h14, 8'h50, 2'd0, 4'd0, 32'h0},
        {1'b0, 5'h17, 8'h00, 2'd1, 4'd2, 32'h0000_5053},
        {1'b0, 5'h08, 8'h00, 2'd3, 4'd7, 32'h0022_1100},
        {1'b1, 5'h0B, 8'h23, 2'd0, 4'd0, 32'h0},
        {1'b0, 5'h0A, 8'h00, 2'd3, 4'd2, 32'h1100_2322},
        {1'b0, 5'h14, 8'h00, 2'd0, 4'd7, 32'h0000_0050},
        {1'b0, 5'h1D, 8'h00, 2'd0, 4'd7, 32'h0000_0000},
        {1'b0, 5'h17, 8'h00, 2'd0, 4'd7, 32'h0000_0053}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic              req_we;
    logic [DATA_W-1:0] req_wdata;
    logic [BL_W-1:0]   req_blen;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              rsp_last;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_bank_ctrl #(
        .ROW_W      (ROW_W),
        .COL_W      (COL_W),
        .DATA_W     (DATA_W),
        .BL_W       (BL_W),
        .OPEN_CYC   (OPEN_C),
        .CLOSE_CYC  (CLOSE_C),
        .REF_PERIOD (REF_P)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_we    (req_we),
        .req_wdata (req_wdata),
        .req_blen  (req_blen),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_last  (rsp_last)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] w);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = w; req_blen = '0;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    // lat = negedge index (after the accepting edge) where the first word shows
    task automatic do_read(input logic [ADDR_W-1:0] a, input logic [BL_W-1:0] bl,
                           output int lat, output int nw, output logic [31:0] d);
        int n;
        bit done;
        d = '0; lat = 0; nw = 0; n = 0; done = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = a; req_blen = bl; req_wdata = '0;
        @(posedge clk);
        #1 req_valid = 1'b0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
            if (n == 1) check(!req_ready, "R10 ready low after accept", 32'(req_ready), 32'd0);
            if (rsp_valid) begin
                if (nw == 0) lat = n;
                if (nw < 4) d[8*nw +: 8] = rsp_data;
                nw++;
                if (rsp_last) done = 1'b1;
            end
        end
    endtask

    task automatic wait_ref(output int t, output int low);
        @(negedge clk);
        while (req_ready) @(negedge clk);
        t = cyc;
        low = 0;
        while (!req_ready) begin
            low++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R10 watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int t1, t2, low, lat, nw;
        logic [31:0] d;
        rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0;
        req_addr = '0; req_wdata = '0; req_blen = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready == 1'b1, "R11 ready in reset", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R11 no response in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R11 ready after reset", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R11 no response after reset", 32'(rsp_valid), 32'd0);

        // First refresh, bank idle with no row open
        wait_ref(t1, low);
        check(low == 3, "R9 refresh busy, no open row", 32'(low), 32'd3);

        // Vector table right after a refresh, so it fits within one period
        for (int i = 0; i < 12; i++) begin
            logic [51:0] v;
            v = TBL[i];
            if (v[51]) begin
                do_write(v[50:46], v[45:38]);
            end else begin
                do_read(v[50:46], v[37:36], lat, nw, d);
                if (v[35:32] == 4'd2)
                    check(lat == 2, "R3 hit latency", 32'(lat), 32'd2);
                else
                    check(lat == 7, "R5 row change latency", 32'(lat), 32'd7);
                check(nw == int'(v[37:36]) + 1, "R6 burst word count", 32'(nw), 32'(v[37:36]) + 32'd1);
                check(d == v[31:0], "R1 R2 R7 read data", d, v[31:0]);
            end
        end

        // Next refresh with row 5 open
        wait_ref(t2, low);
        check(t2 - t1 == REF_P, "R8 refresh period", 32'(t2 - t1), 32'(REF_P));
        check(low == 3 + CLOSE_C, "R9 refresh busy, row open", 32'(low), 32'(3 + CLOSE_C));

        do_read(5'h17, 2'd0, lat, nw, d);
        check(lat == 2 + OPEN_C, "R9 R4 row closed by refresh", 32'(lat), 32'(2 + OPEN_C));
        check(d == 32'h53, "R5 write-back kept data", d, 32'h53);

        // Many refresh rounds, then reread a row untouched meanwhile
        repeat (9 * REF_P) @(negedge clk);
        do_read(5'h08, 2'd3, lat, nw, d);
        check(d == 32'h2322_1100, "R8 data kept across refresh", d, 32'h2322_1100);
        check(lat == 2 + OPEN_C, "R4 closed-bank latency", 32'(lat), 32'(2 + OPEN_C));
        check(nw == 4, "R6 full burst", 32'(nw), 32'd4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule